// File: doc/BRIEF.md
# Extension-Field Cube and Frobenius Unit

This unit takes one element of the degree-six extension field GF(3^6m) and applies one of three maps to it, chosen by a two-bit opcode. The three maps are cubing, raising to q = 3^m, and raising to q². The element is held as six base-field coefficients over GF(3^m), and the coefficient order follows a fixed tower basis. In that basis the two Frobenius powers become sign changes and sums of coefficients, so they cost only additions and subtractions.

Cubing first cubes each of the six coefficients inside the base field, using an adder array that spreads digits to position 3i and then folds them back with the reduction polynomial. It then passes the six cubes through the same sum network as the q-power map.

A fourth opcode passes the operand through untouched. An output register, which is on by default, gives the result one cycle of latency. The unit is meant to sit next to a multiplier in a pairing final-exponentiation datapath, where these maps are used many times between multiplications.

Top module: `ef_cube_frob`

## Requirements
- R1: Every GF(3) digit takes two bits with the high bit first. The value 1 is coded 10 and the value 2 is coded 11. Zero may arrive as 00 or 01. For opcodes 00, 01 and 10, every zero digit of the result is emitted as 00.
- R2: Opcode 01 (raise to q) maps coefficients (a0..a5) to (a0−a2+a4, a3−a1−a5, a2+a4, −a3−a5, a4, −a5), with each digit computed mod 3.
- R3: Opcode 10 (raise to q²) maps (a0..a5) to (a0+a2+a4, a1+a3+a5, a2−a4, a3−a5, a4, a5).
- R4: Opcode 00 (cube) first cubes each coefficient in GF(3^m), reducing by x^m + x^TAP + C0 (default x^97 + x^16 + 2). This gives b0..b5. The output is then (b0−b2+b4, b3−b1−b5, b2+b4, −b3−b5, b4, −b5).
- R5: Opcode 11 copies the input bits to the output unchanged, including any zero digits coded 01.
- R6: With REG_OUT=1, the result for the operand and opcode present at a rising edge appears on y_o after that edge. A synchronous active-high reset clears y_o to all zero bits, and reset takes priority over any operand present in the same cycle.
- R7: Coefficient k occupies bits [k·2m +: 2m] of the bus. Digit i of a coefficient (the coefficient of x^i) occupies bits [2i +: 2] of that slice.
- R8: Feeding the q-power result back through opcode 01 gives, after two passes, the same result as one q²-power. After six passes it gives the canonical form of the original operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_i | input | 2 | Map select: 00 cube, 01 raise to q, 10 raise to q², 11 pass |
| a_i | input | 12·M | Operand, six coefficients of 2·M bits |
| y_o | output | 12·M | Result, same packing as the operand |

## Verification
Two pairs of events can land in the same cycle. The first is a synchronous reset asserted while a live operand and opcode are on the inputs. The bench provokes this both at start-up and in the middle of a run, and requires the register to come out all zeros instead of the map result. The second is a change of opcode in every cycle, including results fed back from y_o as the next operand. Here the value held in the register and the value being presented belong to different maps. A behavioural model is compared on every clock so that a mixed-up stage shows as a wrong map on the wrong cycle. The model computes the cube with full polynomial multiplication rather than digit spreading, and it includes the boundary operand x^(m−1), which exercises the longest chain of reduction folds.

// File: rtl/ef_pkg.sv
package ef_pkg;

    typedef enum logic [1:0] {
        OP_CUBE   = 2'b00,
        OP_FROBQ  = 2'b01,
        OP_FROBQ2 = 2'b10,
        OP_PASS   = 2'b11
    } ef_op_e;

    // value of one two-bit digit code (high bit flags a nonzero digit)
    function automatic int d_val(logic [1:0] c);
        if (!c[1]) return 0;
        return c[0] ? 2 : 1;
    endfunction

    // canonical code of a value 0..2 (zero always 00)
    function automatic logic [1:0] d_enc(int v);
        case (v % 3)
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] d_add(logic [1:0] x, logic [1:0] y);
        return d_enc(d_val(x) + d_val(y));
    endfunction

    function automatic logic [1:0] d_neg(logic [1:0] x);
        return d_enc(3 - d_val(x));
    endfunction

    function automatic logic [1:0] d_sub(logic [1:0] x, logic [1:0] y);
        return d_add(x, d_neg(y));
    endfunction

    function automatic logic [1:0] d_canon(logic [1:0] x);
        return d_enc(d_val(x));
    endfunction

endpackage

// File: rtl/ef_base_cuber.sv
module ef_base_cuber
    import ef_pkg::*;
#(
    parameter int M   = 97,
    parameter int TAP = 16,
    parameter int C0  = 2
) (
    input  logic [2*M-1:0] a,
    output logic [2*M-1:0] y
);
    localparam int SPREAD = 3*M - 2;

    // Spread digit i to x^(3i), then fold from the top using x^M = -x^TAP - C0.
    // Every fold is a constant add/sub, so the whole function is an adder array.
    function automatic logic [2*M-1:0] cube_f(logic [2*M-1:0] x);
        int v [SPREAD];
        int d;
        logic [2*M-1:0] r;
        for (int k = 0; k < SPREAD; k++) v[k] = 0;
        for (int i = 0; i < M; i++) v[3*i] = d_val(x[2*i +: 2]);
        for (int k = SPREAD - 1; k >= M; k--) begin
            d    = v[k];
            v[k] = 0;
            v[k-M+TAP] = (v[k-M+TAP] + 3 - d) % 3;
            v[k-M]     = (v[k-M] + 3 - ((C0 * d) % 3)) % 3;
        end
        r = '0;
        for (int i = 0; i < M; i++) r[2*i +: 2] = d_enc(v[i]);
        return r;
    endfunction

    assign y = cube_f(a);

endmodule

// File: rtl/ef_frob_net.sv
module ef_frob_net
    import ef_pkg::*;
#(
    parameter int M      = 97,
    parameter bit SECOND = 1'b0   // 0: raise to q, 1: raise to q^2
) (
    input  logic [5:0][2*M-1:0] a,
    output logic [5:0][2*M-1:0] y
);
    generate
        if (!SECOND) begin : g_q
            always_comb begin
                y = '0;
                for (int i = 0; i < M; i++) begin
                    y[0][2*i +: 2] = d_add(d_sub(a[0][2*i +: 2], a[2][2*i +: 2]), a[4][2*i +: 2]);
                    y[1][2*i +: 2] = d_sub(d_sub(a[3][2*i +: 2], a[1][2*i +: 2]), a[5][2*i +: 2]);
                    y[2][2*i +: 2] = d_add(a[2][2*i +: 2], a[4][2*i +: 2]);
                    y[3][2*i +: 2] = d_neg(d_add(a[3][2*i +: 2], a[5][2*i +: 2]));
                    y[4][2*i +: 2] = d_canon(a[4][2*i +: 2]);
                    y[5][2*i +: 2] = d_neg(a[5][2*i +: 2]);
                end
            end
        end else begin : g_q2
            always_comb begin
                y = '0;
                for (int i = 0; i < M; i++) begin
                    y[0][2*i +: 2] = d_add(d_add(a[0][2*i +: 2], a[2][2*i +: 2]), a[4][2*i +: 2]);
                    y[1][2*i +: 2] = d_add(d_add(a[1][2*i +: 2], a[3][2*i +: 2]), a[5][2*i +: 2]);
                    y[2][2*i +: 2] = d_sub(a[2][2*i +: 2], a[4][2*i +: 2]);
                    y[3][2*i +: 2] = d_sub(a[3][2*i +: 2], a[5][2*i +: 2]);
                    y[4][2*i +: 2] = d_canon(a[4][2*i +: 2]);
                    y[5][2*i +: 2] = d_canon(a[5][2*i +: 2]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ef_cube_frob.sv
module ef_cube_frob
    import ef_pkg::*;
#(
    parameter int M       = 97,
    parameter int TAP     = 16,
    parameter int C0      = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      op_i,
    input  logic [12*M-1:0] a_i,
    output logic [12*M-1:0] y_o
);
    localparam int CW = 2*M;

    logic [5:0][CW-1:0] a_c, cub, q_src, q_y, q2_y, res_c;

    assign a_c = a_i;

    for (genvar k = 0; k < 6; k++) begin : g_cube
        ef_base_cuber #(.M(M), .TAP(TAP), .C0(C0)) i_cuber (.a(a_c[k]), .y(cub[k]));
    end

    // cube shares the q network: cubing is a q-style shuffle of coefficient cubes
    assign q_src = (ef_op_e'(op_i) == OP_CUBE) ? cub : a_c;

    ef_frob_net #(.M(M), .SECOND(1'b0)) i_net_q  (.a(q_src), .y(q_y));
    ef_frob_net #(.M(M), .SECOND(1'b1)) i_net_q2 (.a(a_c),   .y(q2_y));

    always_comb begin
        case (ef_op_e'(op_i))
            OP_FROBQ2: res_c = q2_y;
            OP_PASS:   res_c = a_c;
            default:   res_c = q_y;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) y_o <= '0;
                else     y_o <= res_c;
            end

            // ---------------- assertions ----------------
            function automatic logic [CW-1:0] canon_v(logic [CW-1:0] x);
                logic [CW-1:0] r;
                for (int i = 0; i < M; i++) r[2*i +: 2] = d_canon(x[2*i +: 2]);
                return r;
            endfunction

            function automatic logic [CW-1:0] neg_v(logic [CW-1:0] x);
                logic [CW-1:0] r;
                for (int i = 0; i < M; i++) r[2*i +: 2] = d_neg(x[2*i +: 2]);
                return r;
            endfunction

            logic armed;
            always_ff @(posedge clk) armed <= ~rst;

            logic [6*M-1:0] alt_zero;
            for (genvar d = 0; d < 6*M; d++) begin : g_alt
                assign alt_zero[d] = ~y_o[2*d+1] & y_o[2*d];
            end

            assert_pass_raw_R5: assert property (@(posedge clk) disable iff (rst)
                (armed && $past(op_i) == OP_PASS) |-> (y_o == $past(a_i)));

            assert_zero_code_R1: assert property (@(posedge clk) disable iff (rst)
                (armed && $past(op_i) != OP_PASS) |-> (alt_zero == '0));

            assert_q_neg5_R2: assert property (@(posedge clk) disable iff (rst)
                (armed && $past(op_i) == OP_FROBQ) |->
                (y_o[5*CW +: CW] == neg_v($past(a_i[5*CW +: CW]))));

            assert_q2_fixed_R3: assert property (@(posedge clk) disable iff (rst)
                (armed && $past(op_i) == OP_FROBQ2) |->
                (y_o[4*CW +: CW] == canon_v($past(a_i[4*CW +: CW])) &&
                 y_o[5*CW +: CW] == canon_v($past(a_i[5*CW +: CW]))));

            assert_cube_c4_R4: assert property (@(posedge clk) disable iff (rst)
                (armed && $past(op_i) == OP_CUBE) |-> (y_o[4*CW +: CW] == $past(cub[4])));
        end else begin : g_comb
            assign y_o = res_c;
        end
    endgenerate

endmodule

// File: tb/test_ef_cube_frob.sv
module test_ef_cube_frob;

    localparam int M   = 97;
    localparam int TAP = 16;
    localparam int C0  = 2;
    localparam int W   = 12*M;
    localparam int CW  = 2*M;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] y_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [W-1:0] exp_q;
    logic [W-1:0] last_y;
    string        exp_tag;
    bit           have_exp = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ef_cube_frob #(.M(M), .TAP(TAP), .C0(C0), .REG_OUT(1'b1)) i_ef_cube_frob (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .y_o(y_o)
    );

    // ---------------- behavioural reference ----------------
    function automatic int dv(logic [1:0] c);
        if (c == 2'b10) return 1;
        if (c == 2'b11) return 2;
        return 0;
    endfunction

    function automatic logic [1:0] de(int v);
        int r;
        r = ((v % 3) + 3) % 3;
        if (r == 1) return 2'b10;
        if (r == 2) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [W-1:0] model(logic [1:0] op, logic [W-1:0] a);
        int x [6][M];
        int b [6][M];
        int o [6][M];
        int p [2*M-1];
        int t [3*M-2];
        logic [W-1:0] r;
        if (op == 2'b11) return a;
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < M; i++) x[c][i] = dv(a[c*CW + 2*i +: 2]);
        if (op == 2'b00) begin
            for (int c = 0; c < 6; c++) begin
                for (int k = 0; k < 2*M-1; k++) p[k] = 0;
                for (int k = 0; k < 3*M-2; k++) t[k] = 0;
                for (int i = 0; i < M; i++)
                    for (int j = 0; j < M; j++) p[i+j] = (p[i+j] + x[c][i]*x[c][j]) % 3;
                for (int i = 0; i < 2*M-1; i++)
                    for (int j = 0; j < M; j++) t[i+j] = (t[i+j] + p[i]*x[c][j]) % 3;
                for (int k = 3*M-3; k >= M; k--) begin
                    t[k-M+TAP] = t[k-M+TAP] - t[k];
                    t[k-M]     = t[k-M] - C0*t[k];
                    t[k] = 0;
                end
                for (int i = 0; i < M; i++) b[c][i] = t[i];
            end
        end else begin
            for (int c = 0; c < 6; c++)
                for (int i = 0; i < M; i++) b[c][i] = x[c][i];
        end
        for (int i = 0; i < M; i++) begin
            if (op == 2'b10) begin
                o[0][i] = b[0][i] + b[2][i] + b[4][i];
                o[1][i] = b[1][i] + b[3][i] + b[5][i];
                o[2][i] = b[2][i] - b[4][i];
                o[3][i] = b[3][i] - b[5][i];
                o[4][i] = b[4][i];
                o[5][i] = b[5][i];
            end else begin
                o[0][i] = b[0][i] - b[2][i] + b[4][i];
                o[1][i] = b[3][i] - b[1][i] - b[5][i];
                o[2][i] = b[2][i] + b[4][i];
                o[3][i] = -b[3][i] - b[5][i];
                o[4][i] = b[4][i];
                o[5][i] = -b[5][i];
            end
        end
        for (int c = 0; c < 6; c++)
            for (int i = 0; i < M; i++) r[c*CW + 2*i +: 2] = de(o[c][i]);
        return r;
    endfunction

    function automatic logic [W-1:0] canon(logic [W-1:0] a);
        logic [W-1:0] r;
        for (int d = 0; d < 6*M; d++) r[2*d +: 2] = de(dv(a[2*d +: 2]));
        return r;
    endfunction

    function automatic logic [W-1:0] rand_vec(int zero_pct);
        logic [W-1:0] r;
        for (int d = 0; d < 6*M; d++) begin
            int v;
            v = (($urandom % 100) < zero_pct) ? 0 : 1 + ($urandom % 2);
            if (v == 0) r[2*d +: 2] = ($urandom % 2) ? 2'b01 : 2'b00;
            else        r[2*d +: 2] = de(v);
        end
        return r;
    endfunction

    // ---------------- checking ----------------
    task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // at each falling edge: compare the registered result, then present the next stimulus
    task automatic step(input logic r, input logic [1:0] op, input logic [W-1:0] a,
                        input bit feed, input string tag);
        logic [W-1:0] v;
        @(negedge clk);
        last_y = y_o;
        if (have_exp) check(y_o, exp_q, exp_tag);
        v = feed ? y_o : a;
        rst  = r;
        op_i = op;
        a_i  = v;
        exp_q   = r ? '0 : model(op, v);
        exp_tag = tag;
        have_exp = 1'b1;
    endtask

    initial begin : watchdog
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v0, zero01, topdig, ones, twos;

        // reset held with live operand: R6 reset priority
        a_i  = rand_vec(30);
        op_i = 2'b01;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(y_o, '0, "R6 reset state");

        // all-zero operand coded 01 everywhere: R1 canonical zero, R5 raw pass
        for (int d = 0; d < 6*M; d++) zero01[2*d +: 2] = 2'b01;
        step(1'b0, 2'b00, zero01, 1'b0, "R1 R4 cube of 01-coded zero");
        step(1'b0, 2'b01, zero01, 1'b0, "R1 R2 q of 01-coded zero");
        step(1'b0, 2'b10, zero01, 1'b0, "R1 R3 q2 of 01-coded zero");
        step(1'b0, 2'b11, zero01, 1'b0, "R5 pass keeps 01 codes");

        // uniform digits
        for (int d = 0; d < 6*M; d++) begin
            ones[2*d +: 2] = 2'b10;
            twos[2*d +: 2] = 2'b11;
        end
        step(1'b0, 2'b00, ones, 1'b0, "R4 cube all ones");
        step(1'b0, 2'b01, twos, 1'b0, "R2 q all twos");
        step(1'b0, 2'b10, ones, 1'b0, "R3 q2 all ones");

        // x^(M-1) in every coefficient: longest fold chain, R4 and R7 top digit
        topdig = '0;
        for (int c = 0; c < 6; c++) topdig[c*CW + 2*(M-1) +: 2] = de(c % 2 + 1);
        step(1'b0, 2'b00, topdig, 1'b0, "R4 R7 cube of top digit");
        // only coefficient k set to 1: R7 coefficient placement
        for (int k = 0; k < 6; k++) begin
            v0 = '0;
            v0[k*CW +: 2] = 2'b10;
            step(1'b0, 2'b01, v0, 1'b0, $sformatf("R7 R2 unit in coefficient %0d", k));
        end

        // random operands, opcode changing every cycle
        for (int n = 0; n < 24; n++) begin
            logic [1:0] op;
            op = 2'(n % 4);
            step(1'b0, op, rand_vec(20 + n), 1'b0,
                 (op == 2'b00) ? "R4 cube random" :
                 (op == 2'b01) ? "R2 q random" :
                 (op == 2'b10) ? "R3 q2 random" : "R5 pass random");
        end

        // R8: feed q result back six times
        v0 = rand_vec(25);
        step(1'b0, 2'b01, v0, 1'b0, "R8 q chain pass 1");
        for (int n = 2; n <= 7; n++) begin
            step(1'b0, 2'b01, '0, 1'b1, "R8 q chain feed");
            if (n == 3) check(last_y, model(2'b10, v0), "R8 q twice equals q2");
            if (n == 7) check(last_y, canon(v0), "R8 q six times is identity");
        end

        // mid-run reset with operand present: R6
        step(1'b1, 2'b00, rand_vec(10), 1'b0, "R6 mid-run reset clears output");
        step(1'b0, 2'b10, rand_vec(40), 1'b0, "R3 q2 after reset");
        step(1'b0, 2'b11, '0, 1'b0, "R5 idle flush");
        @(negedge clk);
        check(y_o, exp_q, exp_tag);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule